// File: doc/BRIEF.md
# Integrity-Checked Page Transfer Engine

This engine sits between a serial slave's byte framing and a byte-wide memory array and carries out page transfers protected by a 16-bit checksum. A page always holds 64 bytes. A transfer opens with a start pulse that carries the direction. Two address bytes follow. For a write, 64 data bytes and two checksum bytes come after that. The engine buffers the data bytes in a local staging store. Only when the received checksum equals its own checksum over the address and the data does it copy the page into the array.

For a read, the engine presents the 64 array bytes one at a time on a byte handshake. It folds each byte into the running checksum as the byte leaves, and then presents the two checksum bytes. A sticky failure flag reports the outcome of the most recent write check. Deasserting select before the second checksum byte abandons the transfer. Nothing reaches the array in that case.

Top module: `sp_secure_page`

## Requirements
- R1: After reset, `fail_flag_o`, `tx_valid_o` and `mem_we_o` are all 0.
- R2: A write whose checksum matches stores its 64 bytes at base, base+1, ..., base+63. The address is 15 bits, so it wraps from 0x7FFF to 0x0000. The stores happen during 64 consecutive `mem_we_o` cycles that start after the last checksum byte.
- R3: The checksum is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, with no reflection and no final XOR, taken MSB first. It runs over the byte {1'b0, addr[14:8]}, then addr[7:0], then the 64 data bytes in order. On the wire the checksum travels high byte first, then low byte.
- R4: A write with corrupted data or a corrupted checksum leaves every array byte unchanged and sets `fail_flag_o` to 1.
- R5: A write whose checksum was computed for a different address leaves both that address's page and the sent address's page unchanged, and sets `fail_flag_o` to 1.
- R6: A write that passes its check clears `fail_flag_o` to 0.
- R7: A read presents array bytes base..base+63 in order, then the checksum high byte, then the low byte. Each byte is held on `tx_byte_o` with `tx_valid_o`=1 until `tx_ack_i`. After the last acknowledge, `tx_valid_o` is 0.
- R8: If `sel_i` drops before the second checksum byte of a write is received, the array is not written and `fail_flag_o` keeps its previous value.
- R9: Bit 7 of the first address byte is ignored. It counts as 0 both for the address and for the checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Transfer select; a low level abandons an open transfer |
| start_i | input | 1 | Opens a transfer (taken in idle while selected) |
| write_i | input | 1 | Direction at start: 1 = write, 0 = read |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| tx_ack_i | input | 1 | Presented byte consumed |
| tx_valid_o | output | 1 | A byte is presented |
| tx_byte_o | output | 8 | Presented byte |
| mem_addr_o | output | 15 | Array address |
| mem_we_o | output | 1 | Array write strobe |
| mem_wdata_o | output | 8 | Array write data |
| mem_rdata_i | input | 8 | Array read data for `mem_addr_o`, combinational |
| fail_flag_o | output | 1 | Most recent write failed its check |

## Verification
The bench aims at the checksum decision from several directions:
- **Corrupted data byte.** An engine that commits first and checks afterwards would alter the array.
- **Checksum computed for a neighbouring address.** An engine that leaves the address out of the checksum would store the page at the wrong place.
- **Select dropped mid-page and between the two checksum bytes.** An engine that ignores select would write, or would disturb the flag.
- **Page straddling address 0x7FFF.** This exposes a missing 15-bit wrap.
- **Address byte with its top bit set.** This catches padding done wrongly.

Read-back compares both data and checksum bytes, so a swapped checksum byte order or a checksum that skips the address would show.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDATA,
        ST_WCRC,
        ST_COMMIT,
        ST_RDATA,
        ST_RCRC
    } sp_state_e;
endpackage

// File: rtl/sp_crc_byte.sv
module sp_crc_byte
    import sp_pkg::*;
(
    input  logic [15:0] crc_i,
    input  logic [7:0]  byte_i,
    output logic [15:0] crc_o
);
    always_comb begin
        logic [15:0] c;
        c = crc_i;
        for (int i = 7; i >= 0; i--) begin
            if (c[15] ^ byte_i[i]) c = {c[14:0], 1'b0} ^ CRC_POLY;
            else                   c = {c[14:0], 1'b0};
        end
        crc_o = c;
    end
endmodule

// File: rtl/sp_stage_buf.sv
module sp_stage_buf #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  logic [7:0]       wdata_i,
    input  logic [IDX_W-1:0] ridx_i,
    output logic [7:0]       rdata_o
);
    logic [7:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) store_q[widx_i] <= wdata_i;
    end

    assign rdata_o = store_q[ridx_i];
endmodule

// File: rtl/sp_secure_page.sv
module sp_secure_page
    import sp_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int PAGE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              start_i,
    input  logic              write_i,
    input  logic              rx_valid_i,
    input  logic [7:0]        rx_byte_i,
    input  logic              tx_ack_i,
    output logic              tx_valid_o,
    output logic [7:0]        tx_byte_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_we_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i,
    output logic              fail_flag_o
);
    localparam int IDX_W = $clog2(PAGE_BYTES);
    localparam int CNT_W = IDX_W + 1;
    localparam int HI_W  = ADDR_W - 8;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PAGE_BYTES - 1);

    typedef struct packed {
        sp_state_e         st;
        logic              wr;
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
        logic [15:0]       crc;
        logic [7:0]        crc_hi;
        logic              fail;
    } regs_t;

    regs_t q, d;
    logic        buf_we;
    logic [7:0]  crc_byte;
    logic [15:0] crc_next;
    logic [7:0]  buf_rdata;

    sp_crc_byte crc_i (
        .crc_i  (q.crc),
        .byte_i (crc_byte),
        .crc_o  (crc_next)
    );

    sp_stage_buf #(.DEPTH(PAGE_BYTES)) buf_i (
        .clk     (clk),
        .we_i    (buf_we),
        .widx_i  (q.cnt[IDX_W-1:0]),
        .wdata_i (rx_byte_i),
        .ridx_i  (q.cnt[IDX_W-1:0]),
        .rdata_o (buf_rdata)
    );

    always_comb begin
        d          = q;
        buf_we     = 1'b0;
        crc_byte   = rx_byte_i;
        tx_valid_o = 1'b0;
        tx_byte_o  = 8'h00;
        mem_we_o   = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i && sel_i) begin
                    d.st  = ST_ADDR;
                    d.wr  = write_i;
                    d.cnt = '0;
                    d.crc = CRC_INIT;
                end
            end
            ST_ADDR: begin
                if (q.cnt == '0) crc_byte = {{(8-HI_W){1'b0}}, rx_byte_i[HI_W-1:0]};
                if (rx_valid_i) begin
                    d.crc = crc_next;
                    if (q.cnt == '0) begin
                        d.base[ADDR_W-1:8] = rx_byte_i[HI_W-1:0];
                        d.cnt = 1;
                    end else begin
                        d.base[7:0] = rx_byte_i;
                        d.cnt = '0;
                        d.st  = q.wr ? ST_WDATA : ST_RDATA;
                    end
                end
            end
            ST_WDATA: begin
                if (rx_valid_i) begin
                    buf_we = 1'b1;
                    d.crc  = crc_next;
                    d.cnt  = q.cnt + 1'b1;
                    if (q.cnt == LAST) begin
                        d.st  = ST_WCRC;
                        d.cnt = '0;
                    end
                end
            end
            ST_WCRC: begin
                if (rx_valid_i) begin
                    if (q.cnt == '0) begin
                        d.crc_hi = rx_byte_i;
                        d.cnt    = 1;
                    end else if ({q.crc_hi, rx_byte_i} == q.crc) begin
                        d.fail = 1'b0;
                        d.cnt  = '0;
                        d.st   = ST_COMMIT;
                    end else begin
                        d.fail = 1'b1;
                        d.st   = ST_IDLE;
                    end
                end
            end
            ST_COMMIT: begin
                mem_we_o = 1'b1;
                d.cnt    = q.cnt + 1'b1;
                if (q.cnt == LAST) d.st = ST_IDLE;
            end
            ST_RDATA: begin
                tx_valid_o = 1'b1;
                tx_byte_o  = mem_rdata_i;
                crc_byte   = mem_rdata_i;
                if (tx_ack_i) begin
                    d.crc = crc_next;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == LAST) begin
                        d.st  = ST_RCRC;
                        d.cnt = '0;
                    end
                end
            end
            ST_RCRC: begin
                tx_valid_o = 1'b1;
                tx_byte_o  = (q.cnt == '0) ? q.crc[15:8] : q.crc[7:0];
                if (tx_ack_i) begin
                    d.cnt = 1;
                    if (q.cnt != '0) d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (!sel_i && q.st != ST_IDLE && q.st != ST_COMMIT) begin
            d.st   = ST_IDLE;
            d.fail = q.fail;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.crc  <= CRC_INIT;
        end else begin
            q <= d;
        end
    end

    assign mem_addr_o  = q.base + ADDR_W'(q.cnt);
    assign mem_wdata_o = buf_rdata;
    assign fail_flag_o = q.fail;

    // R7
    no_we_while_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && tx_valid_o));

    // R2
    commit_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |-> mem_addr_o == $past(mem_addr_o) + ADDR_W'(1));

    // R6
    commit_clean_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> !fail_flag_o);

    // R4
    flag_moves_on_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fail_flag_o) |-> $past(rx_valid_i));

    // R8
    deselect_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_i && !mem_we_o) |=> !mem_we_o);
endmodule

// File: tb/sp_secure_page_tb_top.sv
module sp_secure_page_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, start = 1'b0, wr = 1'b0, rx_valid = 1'b0, tx_ack = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        tx_valid, mem_we, fail;
    logic [7:0]  tx_byte, mem_wdata, mem_rdata;
    logic [14:0] mem_addr;

    int checks = 0;
    int errors = 0;

    logic [7:0] dmem [256];
    logic [7:0] emem [256];
    logic [7:0] pg   [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    sp_secure_page dut_i (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .start_i(start), .write_i(wr),
        .rx_valid_i(rx_valid), .rx_byte_i(rx_byte), .tx_ack_i(tx_ack),
        .tx_valid_o(tx_valid), .tx_byte_o(tx_byte), .mem_addr_o(mem_addr),
        .mem_we_o(mem_we), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .fail_flag_o(fail)
    );

    assign mem_rdata = dmem[mem_addr[7:0]];
    always_ff @(posedge clk) if (mem_we) dmem[mem_addr[7:0]] <= mem_wdata;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_add(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c ^ {b, 8'h00};
        for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    function automatic logic [15:0] page_crc(input logic [14:0] a);
        logic [15:0] c = 16'hFFFF;
        c = crc_add(c, {1'b0, a[14:8]});
        c = crc_add(c, a[7:0]);
        for (int i = 0; i < 64; i++) c = crc_add(c, pg[i]);
        return c;
    endfunction

    function automatic int mem_diff();
        int n = 0;
        for (int i = 0; i < 256; i++) if (dmem[i] !== emem[i]) n++;
        return n;
    endfunction

    task automatic put(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic open_xfer(input logic w);
        @(negedge clk);
        sel = 1'b1; start = 1'b1; wr = w;
        @(negedge clk);
        start = 1'b0;
    endtask

    // abort_at: number of bytes sent before select drops (-1 = none)
    task automatic do_write(input logic [7:0] a_hi, input logic [7:0] a_lo,
                            input logic [15:0] crc, input int abort_at);
        logic [7:0] seq [68];
        seq[0] = a_hi; seq[1] = a_lo;
        for (int i = 0; i < 64; i++) seq[2+i] = pg[i];
        seq[66] = crc[15:8]; seq[67] = crc[7:0];
        open_xfer(1'b1);
        for (int k = 0; k < 68; k++) begin
            if (k == abort_at) break;
            put(seq[k]);
        end
        sel = 1'b0;
        repeat (72) @(negedge clk);
    endtask

    task automatic do_read(input logic [14:0] a, input string tag);
        int bad = 0;
        logic [15:0] c;
        for (int i = 0; i < 64; i++) pg[i] = emem[8'(a + 15'(i))];
        c = page_crc(a);
        open_xfer(1'b0);
        put({1'b0, a[14:8]});
        put(a[7:0]);
        for (int i = 0; i < 64; i++) begin
            if (!tx_valid || tx_byte !== pg[i]) bad++;
            tx_ack = 1'b1; @(negedge clk); tx_ack = 1'b0;
        end
        chk(bad == 0, {tag, " R7 data"}, bad, 0);
        chk(tx_valid && tx_byte == c[15:8], {tag, " R3 crc hi"}, tx_byte, c[15:8]);
        tx_ack = 1'b1; @(negedge clk); tx_ack = 1'b0;
        chk(tx_valid && tx_byte == c[7:0], {tag, " R3 crc lo"}, tx_byte, c[7:0]);
        tx_ack = 1'b1; @(negedge clk); tx_ack = 1'b0;
        chk(!tx_valid, {tag, " R7 end"}, tx_valid, 0);
        sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic fill_pg();
        for (int i = 0; i < 64; i++) pg[i] = 8'($urandom);
    endtask

    task automatic expect_page(input logic [14:0] a);
        for (int i = 0; i < 64; i++) emem[8'(a + 15'(i))] = pg[i];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [14:0] a;
        logic [15:0] c;
        void'($urandom(32'd2718));
        for (int i = 0; i < 256; i++) begin
            dmem[i] = 8'(i * 7 + 3);
            emem[i] = dmem[i];
        end
        repeat (3) @(negedge clk);
        chk(!fail && !tx_valid && !mem_we, "R1 reset", {fail, tx_valid, mem_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: good write across the 15-bit wrap
        a = 15'h7FE0; fill_pg(); c = page_crc(a);
        do_write({1'b0, a[14:8]}, a[7:0], c, -1);
        expect_page(a);
        chk(mem_diff() == 0, "R2 wrap commit", mem_diff(), 0);
        chk(!fail, "R6 flag after pass", fail, 0);
        do_read(a, "wrap read");

        // R4: corrupted data byte
        a = 15'h0140; fill_pg(); c = page_crc(a); pg[17] ^= 8'h04;
        do_write({1'b0, a[14:8]}, a[7:0], c, -1);
        chk(mem_diff() == 0, "R4 array unchanged", mem_diff(), 0);
        chk(fail, "R4 flag set", fail, 1);

        // R6: passing write clears flag
        fill_pg(); c = page_crc(a);
        do_write({1'b0, a[14:8]}, a[7:0], c, -1);
        expect_page(a);
        chk(!fail, "R6 flag cleared", fail, 0);
        chk(mem_diff() == 0, "R2 commit", mem_diff(), 0);

        // R5: checksum for a neighbouring address
        fill_pg(); c = page_crc(15'h0281);
        do_write(8'h02, 8'h80, c, -1);
        chk(mem_diff() == 0, "R5 array unchanged", mem_diff(), 0);
        chk(fail, "R5 flag set", fail, 1);

        // R8: abort mid-page and between checksum bytes
        a = 15'h0300; fill_pg(); c = page_crc(a);
        do_write({1'b0, a[14:8]}, a[7:0], c, 32);
        chk(mem_diff() == 0 && fail, "R8 mid-page abort", mem_diff(), 0);
        do_write({1'b0, a[14:8]}, a[7:0], c, 67);
        chk(mem_diff() == 0 && fail, "R8 crc abort", mem_diff(), 0);

        // R9: top bit of first address byte ignored
        a = 15'h0500; fill_pg(); c = page_crc(a);
        do_write(8'h85, 8'h00, c, -1);
        expect_page(a);
        chk(mem_diff() == 0 && !fail, "R9 msb ignored", mem_diff(), 0);

        // random mix
        for (int it = 0; it < 12; it++) begin
            logic bad;
            a = 15'($urandom); fill_pg(); c = page_crc(a);
            bad = $urandom_range(0, 1) == 1;
            if (bad) c ^= 16'(1 << $urandom_range(0, 15));
            do_write({1'b0, a[14:8]}, a[7:0], c, -1);
            if (!bad) expect_page(a);
            chk(mem_diff() == 0, bad ? "R4 random reject" : "R2 random commit", mem_diff(), 0);
            chk(fail == bad, "R6 random flag", fail, bad);
            do_read(a, "random read");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule